// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the clocked front end of a pipelined cache SRAM with an 18-bit word: 16 data bits and 2 parity bits. At each rising edge it looks at three chip enables, a processor-side address strobe, a controller-side address strobe, an advance input and the write controls. From these it decides whether a read or a write starts, loads the address register and the 2-bit burst counter, and steps the burst through a four-word block in linear or interleaved order. The storage array is held inside the block.

The pad side of the shared data bus is split into `dq_in`, `dq_out` and a driver enable `dq_oe`. The driver enable follows the asynchronous output enable without a clock. It is forced off as soon as write controls are presented, so a bus turnaround never fights the pads.

An asynchronous active-high sleep request passes through a two-flop synchronizer. It then drives a mode machine that takes two cycles to enter sleep and two to leave it. A recovery window follows the exit, and starts are refused during that window. Any burst still open when sleep begins is dropped. The stored words are kept.

Top module: `sync_burst_sram_ctl`

## Requirements
- R1: While reset is held and just after it is released, `dq_oe` is 0 and `in_sleep` is 0.
- R2: A controller-strobe access starts only when `ce_a_n` is 0, `ce_b` is 1 and `ce_c_n` is 0 at the edge. If any one of the three is inactive, the write does not happen and the stored word is unchanged.
- R3: When `ads_proc_n` is 0, `ads_ctl_n` is ignored. A processor-strobe start is always a read, and any write controls present at that edge are ignored.
- R4: With `gwr_n` high, lane i is written only when `bwen_n` is 0 and `bsel_n[i]` is 0. Lane 0 is bits 7:0 plus bit 16. Lane 1 is bits 15:8 plus bit 17. When no lane is selected, a controller-strobe start is a read and memory is unchanged.
- R5: `gwr_n` low writes both lanes, whatever `bwen_n` and `bsel_n` say.
- R6: A read that starts at an edge puts the addressed word on `dq_out` after that edge. `dq_oe` is then 1 for the following cycle if `oe_n` is 0 and no write is presented.
- R7: `dq_oe` is 0 whenever `oe_n` is 1. It is also 0 whenever a selected controller-strobe write is presented, whatever `oe_n` is. Both effects apply at once, without waiting for a clock edge.
- R8: With `burst_ilv` at 0, each advance cycle (`adv_n` 0, both strobes high) reads the next address in linear order: (base + k) mod 4, inside the 4-aligned block.
- R9: With `burst_ilv` at 1, the k-th word of a burst is at (base XOR k) inside the 4-aligned block.
- R10: A strobe that is not ignored but arrives while the chip is not selected ends the burst. Later advance cycles then read nothing and leave `dq_oe` at 0.
- R11: `in_sleep` rises after the fourth edge that samples `sleep_req` high. Any open burst is discarded. While asleep, `dq_oe` is 0, writes are ignored and stored contents are kept.
- R12: `in_sleep` falls after the fourth edge that samples `sleep_req` low. For the next `REC_CYC` edges, starts are ignored. The edge after that window accepts a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| ads_proc_n | input | 1 | Processor-side address strobe, active low, has priority |
| ads_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | ADDR_W | Word address |
| gwr_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 2 | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq_in | input | 18 | Write data from the bus pads |
| dq_out | output | 18 | Read data to the bus pads |
| dq_oe | output | 1 | Pad driver enable for `dq_out` |
| in_sleep | output | 1 | High while the block is in sleep mode |

## Verification
The hardest state to reach from the ports is the recovery window after sleep. Its edges are defined by a synchronizer and two mode transitions, and it can only be observed by a start that fails to take effect. The bench opens a burst, then raises `sleep_req` and counts edges one at a time until `in_sleep` changes. On the last refused edge it presents a write. On the edge after the window it presents an advance, and only then does it read the word back. This shows that the write was refused, that the burst was dropped, and that the contents survived sleep.

// File: rtl/sync_burst_sram_ctl.sv
module sync_burst_sram_ctl #(
  parameter int ADDR_W  = 8,
  parameter int REC_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              ads_proc_n,
  input  logic              ads_ctl_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gwr_n,
  input  logic              bwen_n,
  input  logic [1:0]        bsel_n,
  input  logic              oe_n,
  input  logic              sleep_req,
  input  logic              burst_ilv,
  input  logic [17:0]       dq_in,
  output logic [17:0]       dq_out,
  output logic              dq_oe,
  output logic              in_sleep
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int RCW   = $clog2(REC_CYC + 1);

  typedef enum logic [2:0] {S_AWAKE, S_DOZE, S_ASLEEP, S_WAKE, S_RECOV} slp_t;

  slp_t              st;
  logic              s1, s2;
  logic [RCW-1:0]    rcnt;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        bcnt;
  logic              burst_on, rd_valid;
  logic [17:0]       out_q;
  logic [17:0]       mem [DEPTH];

  logic awake, sel, proc_go, ctl_go, start, desel, cont, wr_now, rd_now;
  logic [1:0] we_req, lane_we, cnt_nxt, low_bits;
  logic [ADDR_W-1:0] acc_addr;
  logic [17:0] wmask;

  assign awake   = (st == S_AWAKE);
  assign sel     = ~ce_a_n & ce_b & ~ce_c_n;
  assign proc_go = awake & ~ads_proc_n & sel;
  assign ctl_go  = awake & ads_proc_n & ~ads_ctl_n & sel;
  assign start   = proc_go | ctl_go;
  assign desel   = awake & (~ads_proc_n | ~ads_ctl_n) & ~sel;
  assign cont    = awake & ads_proc_n & ads_ctl_n & ~adv_n & burst_on;

  assign we_req  = ~gwr_n ? 2'b11 : (~bwen_n ? ~bsel_n : 2'b00);
  assign lane_we = (ctl_go | cont) ? we_req : 2'b00;
  assign wr_now  = |lane_we;
  assign rd_now  = proc_go | ((ctl_go | cont) & ~wr_now);

  assign cnt_nxt  = bcnt + 2'd1;
  assign low_bits = burst_ilv ? (addr_q[1:0] ^ cnt_nxt) : (addr_q[1:0] + cnt_nxt);
  assign acc_addr = start ? addr : {addr_q[ADDR_W-1:2], low_bits};
  assign wmask    = {lane_we[1], lane_we[0], {8{lane_we[1]}}, {8{lane_we[0]}}};

  assign dq_out   = out_q;
  assign dq_oe    = ~oe_n & rd_valid & ~wr_now & awake;
  assign in_sleep = (st == S_ASLEEP) || (st == S_WAKE);

  always_ff @(posedge clk) begin
    if (wr_now) mem[acc_addr] <= (mem[acc_addr] & ~wmask) | (dq_in & wmask);
    if (rd_now) out_q <= mem[acc_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_on <= 1'b0;
      rd_valid <= 1'b0;
      addr_q   <= '0;
      bcnt     <= '0;
    end else begin
      rd_valid <= rd_now;
      if (!awake) begin
        burst_on <= 1'b0;
      end else if (start) begin
        burst_on <= 1'b1;
        addr_q   <= addr;
        bcnt     <= '0;
      end else if (desel) begin
        burst_on <= 1'b0;
      end else if (cont) begin
        bcnt <= cnt_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      st   <= S_AWAKE;
      rcnt <= '0;
    end else begin
      s1 <= sleep_req;
      s2 <= s1;
      case (st)
        S_AWAKE:  if (s2) st <= S_DOZE;
        S_DOZE:   st <= S_ASLEEP;
        S_ASLEEP: if (!s2) st <= S_WAKE;
        S_WAKE: begin
          st   <= S_RECOV;
          rcnt <= '0;
        end
        S_RECOV: begin
          if (rcnt == RCW'(REC_CYC - 1)) st <= S_AWAKE;
          else rcnt <= rcnt + 1'b1;
        end
        default: st <= S_AWAKE;
      endcase
    end
  end
endmodule

module sram_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_a_n,
  input logic ce_b,
  input logic ce_c_n,
  input logic ads_proc_n,
  input logic ads_ctl_n,
  input logic gwr_n,
  input logic oe_n,
  input logic sleep_req,
  input logic dq_oe,
  input logic in_sleep
);
  // R7
  write_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gwr_n && !ads_ctl_n && ads_proc_n && !ce_a_n && ce_b && !ce_c_n) |-> !dq_oe);
  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> !dq_oe);
  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) in_sleep |-> !dq_oe);
  // R11
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sleep) |-> $past(sleep_req, 4));
  // R12
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sleep) |-> !$past(sleep_req, 4));
endmodule

bind sync_burst_sram_ctl sram_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
  .ads_proc_n(ads_proc_n), .ads_ctl_n(ads_ctl_n), .gwr_n(gwr_n), .oe_n(oe_n),
  .sleep_req(sleep_req), .dq_oe(dq_oe), .in_sleep(in_sleep)
);

// File: tb/sync_burst_sram_ctl_bench.sv
module sync_burst_sram_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int RC = 4;

  logic clk = 0, rst_n = 0;
  logic ce_a_n, ce_b, ce_c_n, ads_proc_n, ads_ctl_n, adv_n;
  logic [AW-1:0] addr;
  logic gwr_n, bwen_n, oe_n, sleep_req, burst_ilv;
  logic [1:0] bsel_n;
  logic [17:0] dq_in, dq_out;
  logic dq_oe, in_sleep;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram_ctl #(.ADDR_W(AW), .REC_CYC(RC)) u_sync_burst_sram_ctl (
    .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .ads_proc_n(ads_proc_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n), .addr(addr),
    .gwr_n(gwr_n), .bwen_n(bwen_n), .bsel_n(bsel_n), .oe_n(oe_n),
    .sleep_req(sleep_req), .burst_ilv(burst_ilv), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .in_sleep(in_sleep));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_a_n = 0; ce_b = 1; ce_c_n = 0;
    ads_proc_n = 1; ads_ctl_n = 1; adv_n = 1;
    gwr_n = 1; bwen_n = 1; bsel_n = 2'b11; oe_n = 0; dq_in = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [17:0] d,
                    input logic gw, input logic bw, input logic [1:0] bs);
    idle();
    addr = a; dq_in = d; ads_ctl_n = 0; gwr_n = gw; bwen_n = bw; bsel_n = bs;
    tick();
    idle();
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [17:0] d, output logic oe);
    idle();
    addr = a; ads_proc_n = 0;
    tick();
    d = dq_out; oe = dq_oe;
    idle();
  endtask

  task automatic t_reset();
    chk(dq_oe == 0, "R1 dq_oe", 32'(dq_oe), 0);
    chk(in_sleep == 0, "R1 in_sleep", 32'(in_sleep), 0);
  endtask

  task automatic t_global_write();
    logic [17:0] d; logic oe;
    wr(8'h10, 18'h2A5A5, 0, 1, 2'b11);
    rd(8'h10, d, oe);
    chk(d == 18'h2A5A5, "R5 global write", 32'(d), 32'h2A5A5);
    chk(oe == 1, "R6 dq_oe after read", 32'(oe), 1);
  endtask

  task automatic t_byte_lanes();
    logic [17:0] d; logic oe;
    wr(8'h11, 18'h0, 0, 1, 2'b11);
    wr(8'h11, 18'h3FFFF, 1, 0, 2'b10);
    rd(8'h11, d, oe);
    chk(d == 18'h100FF, "R4 lane0", 32'(d), 32'h100FF);
    wr(8'h12, 18'h0, 0, 1, 2'b11);
    wr(8'h12, 18'h3FFFF, 1, 0, 2'b01);
    rd(8'h12, d, oe);
    chk(d == 18'h2FF00, "R4 lane1", 32'(d), 32'h2FF00);
    wr(8'h12, 18'h3FFFF, 1, 1, 2'b00);
    rd(8'h12, d, oe);
    chk(d == 18'h2FF00, "R4 no lane", 32'(d), 32'h2FF00);
  endtask

  task automatic t_enables();
    logic [17:0] d; logic oe;
    wr(8'h20, 18'h12345, 0, 1, 2'b11);
    for (int i = 0; i < 3; i++) begin
      idle();
      addr = 8'h20; dq_in = 18'h3FFFF; ads_ctl_n = 0; gwr_n = 0;
      if (i == 0) ce_a_n = 1;
      if (i == 1) ce_b = 0;
      if (i == 2) ce_c_n = 1;
      tick();
      idle();
      rd(8'h20, d, oe);
      chk(d == 18'h12345, $sformatf("R2 enable %0d off", i), 32'(d), 32'h12345);
    end
  endtask

  task automatic t_priority();
    logic [17:0] d; logic oe;
    wr(8'h30, 18'h0BEEF, 0, 1, 2'b11);
    idle();
    addr = 8'h30; ads_proc_n = 0; ads_ctl_n = 0; gwr_n = 0; dq_in = 18'h3FFFF;
    tick();
    chk(dq_out == 18'h0BEEF, "R3 proc read", 32'(dq_out), 32'h0BEEF);
    chk(dq_oe == 1, "R3 read drives", 32'(dq_oe), 1);
    idle();
    rd(8'h30, d, oe);
    chk(d == 18'h0BEEF, "R3 no write", 32'(d), 32'h0BEEF);
  endtask

  task automatic t_oe();
    logic [17:0] d; logic oe;
    rd(8'h10, d, oe);
    oe_n = 1; #1;
    chk(dq_oe == 0, "R7 oe_n high", 32'(dq_oe), 0);
    oe_n = 0; #1;
    chk(dq_oe == 1, "R6 oe_n low", 32'(dq_oe), 1);
    addr = 8'h13; ads_ctl_n = 0; gwr_n = 0; dq_in = 18'h11111; #1;
    chk(dq_oe == 0, "R7 write tristate", 32'(dq_oe), 0);
    tick();
    idle();
  endtask

  task automatic t_burst(input logic ilv, input logic [AW-1:0] start_a, input string req);
    logic [17:0] d; logic oe;
    logic [1:0] lo;
    for (int i = 0; i < 4; i++) wr(8'h40 + 8'(i), 18'h100 + 18'(i), 0, 1, 2'b11);
    burst_ilv = ilv;
    rd(start_a, d, oe);
    chk(d == 18'h100 + 18'(start_a[1:0]), {req, " first"}, 32'(d), 32'h100 + 32'(start_a[1:0]));
    for (int k = 1; k < 4; k++) begin
      adv_n = 0;
      tick();
      lo = ilv ? (start_a[1:0] ^ 2'(k)) : (start_a[1:0] + 2'(k));
      chk(dq_out == 18'h100 + 18'(lo), $sformatf("%s beat %0d", req, k), 32'(dq_out), 32'h100 + 32'(lo));
    end
    idle();
    burst_ilv = 0;
  endtask

  task automatic t_deselect();
    logic [17:0] d; logic oe;
    rd(8'h40, d, oe);
    ads_ctl_n = 0; ce_b = 0;
    tick();
    idle();
    adv_n = 0;
    tick();
    chk(dq_oe == 0, "R10 burst ended", 32'(dq_oe), 0);
    idle();
  endtask

  task automatic t_sleep();
    logic [17:0] d; logic oe;
    wr(8'h50, 18'h1ABCD, 0, 1, 2'b11);
    rd(8'h50, d, oe);
    sleep_req = 1;
    for (int i = 1; i <= 4; i++) begin
      tick();
      chk(in_sleep == (i == 4), $sformatf("R11 entry edge %0d", i), 32'(in_sleep), 32'(i == 4));
    end
    chk(dq_oe == 0, "R11 quiet", 32'(dq_oe), 0);
    wr(8'h50, 18'h3FFFF, 0, 1, 2'b11);
    sleep_req = 0;
    for (int i = 1; i <= 4; i++) begin
      tick();
      chk(in_sleep == (i != 4), $sformatf("R12 exit edge %0d", i), 32'(in_sleep), 32'(i != 4));
    end
    for (int i = 0; i < RC - 1; i++) tick();
    wr(8'h50, 18'h22222, 0, 1, 2'b11);
    adv_n = 0;
    tick();
    chk(dq_oe == 0, "R11 burst dropped", 32'(dq_oe), 0);
    idle();
    rd(8'h50, d, oe);
    chk(d == 18'h1ABCD, "R12 recovery ignored write, R11 kept", 32'(d), 32'h1ABCD);
    chk(oe == 1, "R12 start accepted", 32'(oe), 1);
  endtask

  initial begin
    idle();
    addr = '0; sleep_req = 0; burst_ilv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_global_write();
    t_byte_lanes();
    t_enables();
    t_priority();
    t_oe();
    t_burst(0, 8'h42, "R8 linear");
    t_burst(1, 8'h41, "R9 interleaved");
    t_deselect();
    t_sleep();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule